// File: doc/BRIEF.md
# Pushbutton Reference-Value Stepper

This block holds a set-point, such as a target room temperature, and raises it by one unit for each press of a single control input. The value lives between two configurable bounds. An increment taken from the upper bound lands on the lower bound, so repeated presses cycle through every allowed value. A synchronous reset also puts the value back at the lower bound.

The control input is expected to be debounced and synchronized already. A small four-state controller turns each press into exactly one increment. It waits in an idle state for the input to go high. It confirms that the input is still high on the next edge, then spends exactly one cycle in the bump state, where the value register steps. It then waits in a hold state until the input is released. The number of states stays at four whatever the size of the range. Only the width of the value register grows with the range.

Top module: `refstep_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge sets `ref_val` to REF_MIN and returns the controller to idle.
- R2: Suppose `up` is sampled high at rising edge k, after a release, and is still high at edge k+1. Then `ref_val` takes its new value at edge k+2 and not earlier.
- R3: Holding `up` high for any number of cycles gives one increment only. No further increment follows until `up` has been sampled low.
- R4: If `up` is sampled high at exactly one edge from idle and is low at the next, `ref_val` does not change.
- R5: An increment from REF_MIN up to but not including REF_MAX gives the value plus one. An increment from REF_MAX gives REF_MIN. This holds also when the bounds span the full width of the register.
- R6: After reset, `ref_val` always lies between REF_MIN and REF_MAX inclusive.
- R7: The bump state lasts exactly one clock cycle and is always followed by the hold state. `ref_val` changes only at the edge that leaves the bump state and stays steady in every other state.
- R8: A single low sample of `up` in the hold state is enough to re-arm the controller. A press that follows such a one-cycle gap is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up | input | 1 | Debounced, synchronized step request, active high |
| ref_val | output | WIDTH | Current reference value |

## Verification
The bench builds two instances from one stimulus stream. The first has WIDTH=3, REF_MIN=1 and REF_MAX=6, a narrow range whose wrap point lies inside the register width. The second has WIDTH=3, REF_MIN=0 and REF_MAX=7, which selects the full-range increment variant, where the wrap comes from the natural overflow of the adder. With only six or eight values, every increment and both wrap points are covered several times across press lengths of one, two, three and many cycles. The sweep also uses release gaps of one and several cycles and applies a reset in the middle of the run.

// File: rtl/refstep_pkg.sv
// Shared types for the reference-value stepper.
// Assumes nothing beyond a two-bit sequential state code.
package refstep_pkg;

    // Controller states: wait for press, confirm press, step, wait for release.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_BUMP    = 2'd2,
        ST_HOLD    = 2'd3
    } step_state_t;

endpackage

// File: rtl/refstep_fsm.sv
// Press-to-step controller.
// Turns each press of a debounced request into a single one-cycle bump strobe.
// A press must be seen on two consecutive edges. After the bump, the
// controller waits for the release before it accepts another press.
// Assumes `up` is already synchronized to `clk`.
module refstep_fsm
    import refstep_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up,
    output step_state_t state,
    output logic        bump
);

    step_state_t state_q;
    step_state_t state_d;

    // Next-state selection for the four-state handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = up ? ST_CONFIRM : ST_IDLE;
            ST_CONFIRM: state_d = up ? ST_BUMP    : ST_IDLE;
            ST_BUMP:    state_d = ST_HOLD;
            ST_HOLD:    state_d = up ? ST_HOLD    : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;
    assign bump  = (state_q == ST_BUMP);

endmodule

// File: rtl/refstep_succ.sv
// Successor function with wrap between two bounds.
// Gives the value that follows `cur`. After REF_MAX it gives REF_MIN.
// When the bounds span the whole register, the plain adder overflow is used
// and no compare is built.
// Assumes REF_MIN < REF_MAX < 2**WIDTH.
module refstep_succ #(
    parameter int WIDTH   = 8,
    parameter int REF_MIN = 16,
    parameter int REF_MAX = 40
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(REF_MIN);
    localparam logic [WIDTH-1:0] MAX_V = WIDTH'(REF_MAX);
    localparam bit FULL_SPAN = (REF_MIN == 0) && (REF_MAX == (2 ** WIDTH) - 1);

    generate
        if (FULL_SPAN) begin : g_natural
            // Full-range variant: overflow of the adder is the wrap.
            always_comb nxt = cur + 1'b1;
        end else begin : g_bounded
            // Bounded variant: explicit compare against the upper bound.
            always_comb nxt = (cur == MAX_V) ? MIN_V : cur + 1'b1;
        end
    endgenerate

endmodule

// File: rtl/refstep_value.sv
// Reference value register.
// Loads the successor on a bump strobe and holds its value otherwise.
// Reset loads the lower bound.
// Assumes `bump` is high for one cycle per step.
module refstep_value #(
    parameter int WIDTH   = 8,
    parameter int REF_MIN = 16,
    parameter int REF_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(REF_MIN);

    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] succ;

    refstep_succ #(
        .WIDTH  (WIDTH),
        .REF_MIN(REF_MIN),
        .REF_MAX(REF_MAX)
    ) u_succ (
        .cur(value_q),
        .nxt(succ)
    );

    // Value register: steps on bump, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    value_q <= MIN_V;
        else if (bump) value_q <= succ;
        else           value_q <= value_q;
    end

    assign value = value_q;

endmodule

// File: rtl/refstep_top.sv
// Pushbutton reference-value stepper, top level.
// Raises `ref_val` by one unit per press, wrapping from REF_MAX to REF_MIN.
// Assumes `up` is debounced and synchronized, and REF_MIN < REF_MAX < 2**WIDTH.
module refstep_top #(
    parameter int WIDTH   = 8,
    parameter int REF_MIN = 16,
    parameter int REF_MAX = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    output logic [WIDTH-1:0] ref_val
);

    import refstep_pkg::*;

    step_state_t state_w;
    logic        bump_w;

    refstep_fsm u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (up),
        .state(state_w),
        .bump (bump_w)
    );

    refstep_value #(
        .WIDTH  (WIDTH),
        .REF_MIN(REF_MIN),
        .REF_MAX(REF_MAX)
    ) u_value (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (bump_w),
        .value(ref_val)
    );

endmodule

// File: rtl/refstep_chk.sv
// Assertion checker for the stepper, bound to every refstep_top instance.
// Observes the ports and the controller state.
module refstep_chk
    import refstep_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int REF_MIN = 16,
    parameter int REF_MAX = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up,
    input logic [WIDTH-1:0] ref_val,
    input step_state_t      state
);

    localparam logic [WIDTH-1:0] MIN_V = WIDTH'(REF_MIN);
    localparam logic [WIDTH-1:0] MAX_V = WIDTH'(REF_MAX);

    // R2: a press seen in idle moves to confirmation.
    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && up) |=> (state == ST_CONFIRM));

    // R3: while the press is held after the step, stay in hold.
    p_no_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && up) |=> (state == ST_HOLD));

    // R4: a press that ends before confirmation is dropped.
    p_pulse_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIRM && !up) |=> (state == ST_IDLE));

    // R5: the step gives the successor, wrapping at the upper bound.
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUMP) |=>
        (ref_val == (($past(ref_val) == MAX_V) ? MIN_V : WIDTH'($past(ref_val) + 1'b1))));

    // R6: value stays within its bounds.
    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        WIDTH'(ref_val - MIN_V) <= WIDTH'(MAX_V - MIN_V));

    // R7: the bump state lasts one cycle and leads to hold.
    p_bump_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUMP) |=> (state == ST_HOLD));

    // R7: outside the bump state the value does not move.
    p_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BUMP) |=> $stable(ref_val));

    // R8: a single low sample in hold re-arms the controller.
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !up) |=> (state == ST_IDLE));

endmodule

bind refstep_top refstep_chk #(
    .WIDTH  (WIDTH),
    .REF_MIN(REF_MIN),
    .REF_MAX(REF_MAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .up     (up),
    .ref_val(ref_val),
    .state  (state_w)
);

// File: tb/refstep_top_tb.sv
`timescale 1ns/1ps
// Bench: two small configurations driven by one stimulus stream.
// Expected values are computed arithmetically.
module refstep_top_tb;

    localparam int W = 3;
    localparam int A_MIN = 1, A_MAX = 6;
    localparam int B_MIN = 0, B_MAX = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up = 1'b0;
    logic [W-1:0] ref_a, ref_b;

    int total = 0;
    int bad   = 0;
    int exp_a, exp_b;

    always #2 clk = ~clk;

    refstep_top #(.WIDTH(W), .REF_MIN(A_MIN), .REF_MAX(A_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .up(up), .ref_val(ref_a));

    refstep_top #(.WIDTH(W), .REF_MIN(B_MIN), .REF_MAX(B_MAX)) u_dut_full (
        .clk(clk), .rst_n(rst_n), .up(up), .ref_val(ref_b));

    function automatic int succ(int v, int lo, int hi);
        return (v == hi) ? lo : v + 1;
    endfunction

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic chk_both(string req);
        chk({req, " narrow"}, int'(ref_a), exp_a);
        chk({req, " full"},   int'(ref_b), exp_b);
    endtask

    // Hold up for `hold` edges, then release for `gap` edges.
    task automatic press(int hold, int gap);
        up = 1'b1;
        for (int i = 1; i <= hold; i++) begin
            @(negedge clk);
            if (i == 2) chk_both("R7 no change before bump edge");
            if (i == 3) begin
                exp_a = succ(exp_a, A_MIN, A_MAX);
                exp_b = succ(exp_b, B_MIN, B_MAX);
                chk_both("R2 step at third edge");
            end
        end
        up = 1'b0;
        if (hold == 2) begin
            exp_a = succ(exp_a, A_MIN, A_MAX);
            exp_b = succ(exp_b, B_MIN, B_MAX);
        end
        for (int j = 0; j < gap; j++) @(negedge clk);
        if (hold == 1) chk_both("R4 single-edge pulse ignored");
        else if (hold > 3) chk_both("R3 long hold gives one step");
        else chk_both("R5 successor with wrap");
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_a = A_MIN;
        exp_b = B_MIN;
        repeat (5) @(negedge clk);
        chk_both("R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        chk_both("R1 after release");

        // R5 R6: three laps of clean two-edge presses.
        for (int k = 0; k < 24; k++) press(2, 2);
        // R3: long holds, and R2 timing with three-edge presses.
        for (int k = 0; k < 8; k++) press((k % 2) ? 12 : 3, 3);
        // R4: single-edge pulses mixed with real presses.
        for (int k = 0; k < 6; k++) begin
            press(1, 2);
            press(2, 2);
        end
        // R8: one-cycle release gaps between presses.
        for (int k = 0; k < 10; k++) press(3, 1);
        @(negedge clk);
        chk_both("R8 presses after one-cycle gap");

        // R1: reset in the middle of the run.
        press(2, 1);
        rst_n = 1'b0;
        @(negedge clk);
        exp_a = A_MIN;
        exp_b = B_MIN;
        chk_both("R1 mid-run reset");
        rst_n = 1'b1;
        press(2, 2);
        press(7, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule